// File: doc/BRIEF.md
# High-Voltage Bias Rail Sequencer

This block controls the enables of the three high-voltage supply rails of a micromirror array: the offset rail, the bias rail and the reset rail. When projection is requested and the low-voltage supplies report good, it turns the rails on one at a time. Offset comes first, then bias, then reset. The gaps between them are set by two delay codes in a small configuration register file. When projection is withdrawn, it runs a graceful shutdown with fixed gaps. Bias and reset regulation stop first. Offset stops later, and at that point the array reset is asserted. The three rails are then discharged, and the internal array-enable signal is dropped.

When the fault input rises, the interrupt output goes low. If fast shutdown is enabled, the block stops bias and reset after a first programmable delay. After a second programmable delay it discharges all rails, asserts the array reset and drops array-enable. If fast shutdown is disabled, a fault only asserts the interrupt and the graceful timing is used instead. All timing runs from a 1 µs tick divided down from the system clock.

The state machine has eleven states:

| State | Meaning |
|-------|---------|
| ST_IDLE | Waiting to start. |
| ST_PU_OFS | Offset rail on; timing the offset-to-bias gap. |
| ST_PU_BIAS | Offset and bias on; timing the bias-to-reset gap. |
| ST_ON | All three rails on. |
| ST_ND_WAIT | Rails held; timing the first graceful gap. |
| ST_ND_OFS | Offset only; timing the second graceful gap. |
| ST_ND_RST | Rails off and reset asserted; waiting before discharge. |
| ST_DISCH | Rails discharging. |
| ST_F_DLY1 | Fault; rails held for the first fault delay. |
| ST_F_DLY2 | Fault; offset only for the second fault delay. |
| ST_F_DONE | Fault shutdown complete. |

Transitions:

- Start: IDLE to PU_OFS.
- Power-up gaps: PU_OFS to PU_BIAS, and PU_BIAS to ON, each when its gap expires.
- Graceful shutdown: ON, PU_OFS or PU_BIAS go to ND_WAIT when projection is dropped. This path then runs ND_WAIT to ND_OFS, ND_OFS to ND_RST, and ND_RST to DISCH.
- Fast fault: PU_OFS, PU_BIAS, ON, ND_WAIT or ND_OFS go to F_DLY1 on a fault when fast shutdown is enabled. The fault path then runs F_DLY1 to F_DLY2 and F_DLY2 to F_DONE.
- Fault with fast shutdown disabled: PU_OFS, PU_BIAS or ON go to ND_WAIT.
- Return: DISCH or F_DONE go back to IDLE once projection is low and the fault is clear.

Top module: `hv_rail_seq`

## Requirements
- R1: After reset and while idle, all rail enables and discharge are low, the device reset is low, the interrupt is high and array-enable is low. Start-up begins only while the projection request is high, the low-voltage good input is high and no fault is present. Start-up turns on only the offset rail, and raises device reset and array-enable.
- R2: Bias turns on (PU_STEP_US × (code+1)) µs after offset, where the code is the byte at address 0x10. Reset turns on the same way after bias, using the code at address 0x11. Both codes reset to 4. Bias is never on without offset, and reset is never on without bias.
- R3: When the projection request drops with all rails on, bias and reset turn off GRACE1_US µs later and offset stays on.
- R4: GRACE2_US µs after bias and reset turn off in a graceful shutdown, offset turns off and the device reset goes low. DISCH_US µs after that, discharge goes high and array-enable goes low. Discharge is never high while any rail enable is high.
- R5: The interrupt output stays high for a whole graceful shutdown when no fault occurs.
- R6: A high fault input drives the interrupt low on the next clock. With fast shutdown enabled, bias and reset turn off (4 + 73 × c1) µs after the fault while offset stays on. Here c1 is bits [3:0] of address 0x0F, which reset to 7.
- R7: (4 + 73 × c2) µs after bias and reset turn off in a fast shutdown, offset turns off, discharge goes high, device reset goes low and array-enable goes low. Here c2 is bits [7:4] of address 0x0F, which reset to 0.
- R8: Fast shutdown is enabled by bit 0 of address 0x01, which resets to 1. When it is 0, a fault in the on state drives the interrupt low and the rails follow the graceful timing of R3 and R4.
- R9: A fault during power-up stops the sequence and enters the fault path with only the rails already on held. After a shutdown, the block returns to idle only when the projection request is low and the fault is clear. The interrupt stays low until then.
- R10: A configuration write to any address other than 0x01, 0x0F, 0x10 and 0x11 changes no delay and no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proj_en | input | 1 | Projection request |
| lv_good | input | 1 | Low-voltage supplies good |
| fault | input | 1 | Fault flag from the monitors |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| en_offset | output | 1 | Offset rail regulate enable |
| en_bias | output | 1 | Bias rail regulate enable |
| en_reset | output | 1 | Reset rail regulate enable |
| discharge | output | 1 | Discharge command for all three rails |
| dev_reset_n | output | 1 | Active-low array reset |
| irq_n | output | 1 | Active-low interrupt |
| array_en | output | 1 | Internal array-enable |

## Verification
The checker assumes that the fault input is a level that stays high until the sequencer has at least entered its fault path. It also assumes that configuration writes do not land in the middle of a gap that is being timed. The stimulus raises the fault and holds it through the fault delays, and lowers it only after the shutdown state is reached. All register writes are made while the sequencer is idle. The bench measures each output change relative to the previous one, so the tick phase never accumulates beyond a few cycles of tolerance.

// File: rtl/hv_seq_pkg.sv
package hv_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_PU_OFS, ST_PU_BIAS, ST_ON,
        ST_ND_WAIT, ST_ND_OFS, ST_ND_RST, ST_DISCH,
        ST_F_DLY1, ST_F_DLY2, ST_F_DONE
    } seq_state_e;

    localparam logic [7:0] ADDR_FAST  = 8'h01;
    localparam logic [7:0] ADDR_FDLY  = 8'h0F;
    localparam logic [7:0] ADDR_GAP1  = 8'h10;
    localparam logic [7:0] ADDR_GAP2  = 8'h11;
endpackage

// File: rtl/hv_tick_gen.sv
module hv_tick_gen #(
    parameter int CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/hv_delay_timer.sv
module hv_delay_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hv_cfg_regs.sv
module hv_cfg_regs
    import hv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       fast_en,
    output logic [3:0] fdly1,
    output logic [3:0] fdly2,
    output logic [7:0] gap1,
    output logic [7:0] gap2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_en <= 1'b1;
            fdly1   <= 4'd7;
            fdly2   <= 4'd0;
            gap1    <= 8'd4;
            gap2    <= 8'd4;
        end else if (we) begin
            unique case (addr)
                ADDR_FAST: fast_en <= wdata[0];
                ADDR_FDLY: begin
                    fdly1 <= wdata[3:0];
                    fdly2 <= wdata[7:4];
                end
                ADDR_GAP1: gap1 <= wdata;
                ADDR_GAP2: gap2 <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hv_rail_seq.sv
module hv_rail_seq
    import hv_seq_pkg::*;
#(
    parameter int CLK_PER_US  = 200,
    parameter int PU_STEP_US  = 1000,
    parameter int GRACE1_US   = 25000,
    parameter int GRACE2_US   = 10000,
    parameter int DISCH_US    = 1000,
    parameter int FLT_BASE_US = 4,
    parameter int FLT_STEP_US = 73,
    parameter int CNT_W       = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proj_en,
    input  logic       lv_good,
    input  logic       fault,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic       en_offset,
    output logic       en_bias,
    output logic       en_reset,
    output logic       discharge,
    output logic       dev_reset_n,
    output logic       irq_n,
    output logic       array_en
);
    localparam logic [CNT_W-1:0] PU_STEP = CNT_W'(PU_STEP_US);
    localparam logic [CNT_W-1:0] F_BASE  = CNT_W'(FLT_BASE_US);
    localparam logic [CNT_W-1:0] F_STEP  = CNT_W'(FLT_STEP_US);

    seq_state_e       st_q, st_d;
    logic             tick, expired, load;
    logic [CNT_W-1:0] load_val;
    logic             fast_en;
    logic [3:0]       fdly1, fdly2;
    logic [7:0]       gap1, gap2;
    logic [2:0]       held_q;
    logic             flt_q;
    logic             hold_entry;

    hv_tick_gen #(.CLK_PER_US(CLK_PER_US)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    hv_delay_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(tick), .expired(expired)
    );

    hv_cfg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .fast_en(fast_en), .fdly1(fdly1),
        .fdly2(fdly2), .gap1(gap1), .gap2(gap2)
    );

    // Next state and the timer value for the state being entered
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:
                if (proj_en && lv_good && !fault) st_d = ST_PU_OFS;
            ST_PU_OFS, ST_PU_BIAS, ST_ON: begin
                if (fault)         st_d = fast_en ? ST_F_DLY1 : ST_ND_WAIT;
                else if (!proj_en) st_d = ST_ND_WAIT;
                else if (expired && st_q == ST_PU_OFS)  st_d = ST_PU_BIAS;
                else if (expired && st_q == ST_PU_BIAS) st_d = ST_ON;
            end
            ST_ND_WAIT:
                if (fault && fast_en) st_d = ST_F_DLY1;
                else if (expired)     st_d = ST_ND_OFS;
            ST_ND_OFS:
                if (fault && fast_en) st_d = ST_F_DLY1;
                else if (expired)     st_d = ST_ND_RST;
            ST_ND_RST:  if (expired) st_d = ST_DISCH;
            ST_F_DLY1:  if (expired) st_d = ST_F_DLY2;
            ST_F_DLY2:  if (expired) st_d = ST_F_DONE;
            ST_DISCH, ST_F_DONE:
                if (!proj_en && !fault) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase

        load = (st_d != st_q);
        unique case (st_d)
            ST_PU_OFS:  load_val = (CNT_W'(gap1) + 1'b1) * PU_STEP;
            ST_PU_BIAS: load_val = (CNT_W'(gap2) + 1'b1) * PU_STEP;
            ST_ND_WAIT: load_val = CNT_W'(GRACE1_US);
            ST_ND_OFS:  load_val = CNT_W'(GRACE2_US);
            ST_ND_RST:  load_val = CNT_W'(DISCH_US);
            ST_F_DLY1:  load_val = F_BASE + CNT_W'(fdly1) * F_STEP;
            ST_F_DLY2:  load_val = F_BASE + CNT_W'(fdly2) * F_STEP;
            default:    load_val = '0;
        endcase
    end

    assign hold_entry = load && (st_d == ST_ND_WAIT || st_d == ST_F_DLY1);

    // State register, held rail mask and fault latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            held_q <= '0;
            flt_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (hold_entry) held_q <= {en_reset, en_bias, en_offset};
            if (fault)                  flt_q <= 1'b1;
            else if (st_q == ST_IDLE)   flt_q <= 1'b0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        {en_reset, en_bias, en_offset} = 3'b000;
        discharge   = 1'b0;
        dev_reset_n = 1'b0;
        array_en    = 1'b0;
        unique case (st_q)
            ST_PU_OFS, ST_ND_OFS, ST_F_DLY2: begin
                en_offset = 1'b1; dev_reset_n = 1'b1; array_en = 1'b1;
            end
            ST_PU_BIAS: begin
                {en_bias, en_offset} = 2'b11; dev_reset_n = 1'b1; array_en = 1'b1;
            end
            ST_ON: begin
                {en_reset, en_bias, en_offset} = 3'b111;
                dev_reset_n = 1'b1; array_en = 1'b1;
            end
            ST_ND_WAIT, ST_F_DLY1: begin
                {en_reset, en_bias, en_offset} = held_q;
                dev_reset_n = 1'b1; array_en = 1'b1;
            end
            ST_ND_RST: array_en = 1'b1;
            ST_DISCH, ST_F_DONE: discharge = 1'b1;
            default: ;
        endcase
    end

    assign irq_n = !flt_q;
endmodule

// File: rtl/hv_rail_seq_chk.sv
module hv_rail_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic en_offset,
    input logic en_bias,
    input logic en_reset,
    input logic discharge,
    input logic dev_reset_n,
    input logic irq_n,
    input logic array_en
);
    // R2
    bias_needs_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_bias |-> en_offset);

    // R2
    reset_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_reset |-> en_bias);

    // R4
    disch_rails_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> !(en_offset || en_bias || en_reset));

    // R7
    disch_dev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge |-> (!dev_reset_n && !array_en));

    // R6
    fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !irq_n);

    // R9
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && (en_offset || discharge)) |=> !irq_n);
endmodule

bind hv_rail_seq hv_rail_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fault(fault), .en_offset(en_offset),
    .en_bias(en_bias), .en_reset(en_reset), .discharge(discharge),
    .dev_reset_n(dev_reset_n), .irq_n(irq_n), .array_en(array_en)
);

// File: tb/hv_rail_seq_tb.sv
`timescale 1ns/1ps
module hv_rail_seq_tb_top;
    localparam int CPU = 2;
    localparam int G1 = 250, G2 = 100, DU = 10, STEP = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic proj_en = 1'b0, lv_good = 1'b0, fault = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0, cfg_wdata = '0;
    logic en_offset, en_bias, en_reset, discharge, dev_reset_n, irq_n, array_en;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hv_rail_seq #(.CLK_PER_US(CPU), .PU_STEP_US(STEP), .GRACE1_US(G1),
                  .GRACE2_US(G2), .DISCH_US(DU)) dut_i (
        .clk(clk), .rst_n(rst_n), .proj_en(proj_en), .lv_good(lv_good),
        .fault(fault), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .en_offset(en_offset), .en_bias(en_bias),
        .en_reset(en_reset), .discharge(discharge), .dev_reset_n(dev_reset_n),
        .irq_n(irq_n), .array_en(array_en));

    // {array_en, irq_n, dev_reset_n, discharge, en_reset, en_bias, en_offset}
    localparam logic [6:0] V_IDLE = 7'b0100000, V_OFS = 7'b1110001,
        V_BIAS = 7'b1110011, V_ON = 7'b1110111, V_RST = 7'b1100000,
        V_DIS = 7'b0101000, VF_ON = 7'b1010111, VF_OFS = 7'b1010001,
        VF_RST = 7'b1000000, VF_DIS = 7'b0001000;

    function automatic logic [6:0] obs();
        return {array_en, irq_n, dev_reset_n, discharge, en_reset, en_bias, en_offset};
    endfunction

    task automatic check_now(input string tag, input logic [6:0] exp);
        total++;
        if (obs() !== exp) begin
            bad++;
            $display("FAIL %s: outputs %b expected %b", tag, obs(), exp);
        end
    endtask

    // wait for the outputs to reach exp, about nom_us after the previous change
    task automatic step(input string tag, input logic [6:0] exp, input int nom_us);
        int cyc = 0;
        while (obs() !== exp && cyc < nom_us * CPU + 40) begin
            @(negedge clk); cyc++;
        end
        total++;
        if (obs() !== exp) begin
            bad++;
            $display("FAIL %s: outputs %b expected %b", tag, obs(), exp);
        end else if (cyc > nom_us * CPU + 4 || cyc + 4 < nom_us * CPU) begin
            bad++;
            $display("FAIL %s: took %0d cycles expected %0d", tag, cyc, nom_us * CPU);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic idle_us(input int n);
        repeat (n * CPU) @(negedge clk);
    endtask

    task automatic power_up(input string tag, input int g1, input int g2);
        @(negedge clk); proj_en = 1'b1; lv_good = 1'b1;
        step({tag, " R1 offset first"}, V_OFS, 0);
        step({tag, " R2 bias gap"}, V_BIAS, g1);
        step({tag, " R2 reset gap"}, V_ON, g2);
    endtask

    task automatic t_reset_and_hold();
        check_now("R1 reset state", V_IDLE);
        @(negedge clk); proj_en = 1'b1;
        idle_us(10);
        check_now("R1 no start without lv_good", V_IDLE);
        proj_en = 1'b0;
    endtask

    task automatic t_graceful();
        power_up("default", 5 * STEP, 5 * STEP);
        @(negedge clk); proj_en = 1'b0;
        step("R3 bias/reset stop, R5 irq high", V_OFS, G1);
        step("R4 offset stop and reset low, R5", V_RST, G2);
        step("R4 discharge, R5", V_DIS, DU);
        step("R9 back to idle", V_IDLE, 0);
    endtask

    task automatic t_regs();
        wr(8'h22, 8'h00);
        wr(8'h10, 8'd9);
        wr(8'h11, 8'd1);
        wr(8'h05, 8'hFF);  // R10 unused address
        power_up("R10 programmed", 10 * STEP, 2 * STEP);
        @(negedge clk); proj_en = 1'b0;
        step("R3 again", V_OFS, G1);
        step("R4 again", V_RST, G2);
        step("R4 disch again", V_DIS, DU);
        step("R9 idle again", V_IDLE, 0);
    endtask

    task automatic fast_fault(input string tag, input int d1, input int d2);
        @(negedge clk); fault = 1'b1;
        step({tag, " R6 irq low"}, VF_ON, 0);
        step({tag, " R6 first delay"}, VF_OFS, d1);
        step({tag, " R7 second delay"}, VF_DIS, d2);
        idle_us(20);
        check_now({tag, " R9 held with fault"}, VF_DIS);
        fault = 1'b0;
        idle_us(5);
        check_now({tag, " R9 held with proj_en"}, VF_DIS);
        proj_en = 1'b0;
        step({tag, " R9 idle"}, V_IDLE, 0);
    endtask

    task automatic t_fast_default();
        power_up("pre-fault", 10 * STEP, 2 * STEP);
        fast_fault("default codes", 4 + 7 * 73, 4);
    endtask

    task automatic t_fast_codes();
        wr(8'h0F, 8'h2F);
        power_up("pre-fault2", 10 * STEP, 2 * STEP);
        fast_fault("codes 15/2", 4 + 15 * 73, 4 + 2 * 73);
    endtask

    task automatic t_fast_off();
        wr(8'h01, 8'h00);
        power_up("pre-fault3", 10 * STEP, 2 * STEP);
        @(negedge clk); fault = 1'b1;
        step("R8 irq low, rails held", VF_ON, 0);
        step("R8 graceful gap 1", VF_OFS, G1);
        step("R8 graceful gap 2", VF_RST, G2);
        step("R8 discharge", VF_DIS, DU);
        idle_us(5);
        check_now("R8 held while fault", VF_DIS);
        fault = 1'b0; proj_en = 1'b0;
        step("R8 idle", V_IDLE, 0);
        wr(8'h01, 8'h01);
    endtask

    task automatic t_preempt();
        @(negedge clk); proj_en = 1'b1;
        step("R9 start", V_OFS, 0);
        idle_us(10);
        fault = 1'b1;
        step("R9 preempt offset held", VF_OFS, 0);
        step("R9 preempt discharge", VF_DIS, (4 + 15 * 73) + (4 + 2 * 73));
        fault = 1'b0; proj_en = 1'b0;
        step("R9 preempt idle", V_IDLE, 0);
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_hold();
        t_graceful();
        t_regs();
        t_fast_default();
        t_fast_codes();
        t_fast_off();
        t_preempt();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule